// File: doc/BRIEF.md
# Packed Halfword Signed Add/Subtract Unit

This block runs one packed arithmetic operation per accepted request on two 32-bit operands, each split into two signed 16-bit lanes. A 4-bit operation code selects among three modes: both lanes add, both lanes subtract, or a crossed mode. In the crossed mode the low lane takes the first operand's low half minus the second operand's high half, and the high lane takes the first operand's high half plus the second operand's low half. Each lane is widened by one sign bit before the arithmetic, so nothing is lost before the sign is read. The packed result keeps only the low 16 bits of each lane. A duplicated pair of greater-or-equal flags per lane records whether that lane's full-precision value is non-negative.

The request also carries the two source register indices and the destination index, plus a condition-enable bit. The unit rejects any request that names register 15 or uses an unknown operation code, and it raises an illegal indication for it. A legal request whose condition is false leaves the held result and flags as they were. The response appears on registered outputs exactly one cycle after the request.

Top module: `phsimd_unit`

## Requirements
- R1: Operation code 4'b0001 adds per lane: result[15:0] is the low 16 bits of a[15:0]+b[15:0], and result[31:16] is the low 16 bits of a[31:16]+b[31:16], both taken as signed.
- R2: Operation code 4'b0111 subtracts per lane: result[15:0] is the low 16 bits of a[15:0]-b[15:0], and result[31:16] is the low 16 bits of a[31:16]-b[31:16].
- R3: Operation code 4'b0011 crosses the lanes: result[15:0] is the low 16 bits of a[15:0]-b[31:16], and result[31:16] is the low 16 bits of a[31:16]+b[15:0].
- R4: Each lane is computed at 17-bit signed precision. The packed output holds the lane-0 value in bits 15:0 and the lane-1 value in bits 31:16, each truncated to 16 bits only at packing.
- R5: ge_flags[1:0] are both 1 when the full-precision lane-0 value is non-negative and both 0 otherwise. ge_flags[3:2] follow lane 1 in the same way.
- R6: out_valid is 1 in exactly the cycle after a cycle with in_valid high, and 0 otherwise. out_write, illegal and out_dst belong to that request.
- R7: A request whose src_a_idx, src_b_idx or dst_idx equals 15 gives illegal=1 and out_write=0, and leaves result and ge_flags unchanged.
- R8: An operation code other than 0001, 0111 or 0011 gives illegal=1 and out_write=0, and leaves result and ge_flags unchanged.
- R9: A legal request with cond_en=0 gives out_write=0 and illegal=0, and leaves result and ge_flags unchanged.
- R10: After a synchronous active-low reset, result, ge_flags, out_valid, out_write, illegal and out_dst are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 4 | Operation code (0001 add, 0111 sub, 0011 crossed) |
| src_a_idx | input | 4 | First source register index |
| src_b_idx | input | 4 | Second source register index |
| dst_idx | input | 4 | Destination register index |
| opnd_a | input | 32 | First packed operand |
| opnd_b | input | 32 | Second packed operand |
| cond_en | input | 1 | Commit enable for a legal request |
| out_valid | output | 1 | Response strobe, one cycle after in_valid |
| out_write | output | 1 | Response committed a new result |
| out_dst | output | 4 | Destination index of the response |
| result | output | 32 | Held packed result |
| ge_flags | output | 4 | Held greater-or-equal flags, two per lane |
| illegal | output | 1 | Response was rejected |

## Verification
Each mode is run with small mixed-sign values, where a swapped or crossed lane shows up at once. It is also run with extreme halves (0x7FFF, 0x8000, 0xFFFF) that push the 17-bit sum past the 16-bit range. There the flags separate a full-precision sign from the sign bit of the truncated field, so a design that reads bit 15 is caught. Using different values in the two lanes of operand b separates the crossed mode from plain add and subtract. Rejected requests and requests with the condition off are sent after a known result is held, so any unwanted write changes a value the bench can see.

// File: rtl/phs_pkg.sv
// Package: shared mode encoding and operation codes for the packed
// halfword add/subtract unit. Assumes 4-bit operation codes.
package phs_pkg;
    typedef enum logic [1:0] {
        MODE_ADD  = 2'd0,
        MODE_SUB  = 2'd1,
        MODE_XCH  = 2'd2,
        MODE_NONE = 2'd3
    } phs_mode_e;

    localparam logic [3:0] OPC_ADD = 4'b0001;
    localparam logic [3:0] OPC_SUB = 4'b0111;
    localparam logic [3:0] OPC_XCH = 4'b0011;
endpackage

// File: rtl/phs_decode.sv
// Decoder: turns the operation code into a lane mode and judges whether
// the request is legal. It assumes that FORBIDDEN_IDX is the one register
// index the unit refuses, whether used as a source or as the destination.
module phs_decode
    import phs_pkg::*;
#(
    parameter int IDX_W         = 4,
    parameter int FORBIDDEN_IDX = 15
) (
    input  logic [3:0]       op_code,
    input  logic [IDX_W-1:0] src_a_idx,
    input  logic [IDX_W-1:0] src_b_idx,
    input  logic [IDX_W-1:0] dst_idx,
    output phs_mode_e        mode,
    output logic             legal
);
    localparam logic [IDX_W-1:0] BAD_IDX = IDX_W'(FORBIDDEN_IDX);

    logic idx_bad;

    // Map the operation code to a mode; unknown codes map to MODE_NONE.
    always_comb begin
        unique case (op_code)
            OPC_ADD: mode = MODE_ADD;
            OPC_SUB: mode = MODE_SUB;
            OPC_XCH: mode = MODE_XCH;
            default: mode = MODE_NONE;
        endcase
    end

    // Legal only when the mode is known and no index is the forbidden one.
    always_comb begin
        idx_bad = (src_a_idx == BAD_IDX) || (src_b_idx == BAD_IDX) ||
                  (dst_idx == BAD_IDX);
        legal   = (mode != MODE_NONE) && !idx_bad;
    end
endmodule

// File: rtl/phs_lane.sv
// Lane: a single signed lane of width LANE_W. It widens both inputs by
// one sign bit and adds or subtracts them, so the result can never
// overflow. EVEN_LANE chooses this lane's role in the crossed mode: even
// lanes subtract the partner half, odd lanes add it.
module phs_lane
    import phs_pkg::*;
#(
    parameter int LANE_W    = 16,
    parameter bit EVEN_LANE = 1'b1
) (
    input  phs_mode_e          mode,
    input  logic [LANE_W-1:0]  a_half,
    input  logic [LANE_W-1:0]  b_same,
    input  logic [LANE_W-1:0]  b_cross,
    output logic [LANE_W:0]    lane_res
);
    logic [LANE_W-1:0] b_pick;
    logic              do_sub;
    logic [LANE_W:0]   a_x;
    logic [LANE_W:0]   b_x;

    // Pick the partner half and the operation for this lane.
    always_comb begin
        b_pick = (mode == MODE_XCH) ? b_cross : b_same;
        do_sub = (mode == MODE_SUB) || ((mode == MODE_XCH) && EVEN_LANE);
    end

    // Sign-extend by one bit and form the full-precision lane value.
    always_comb begin
        a_x      = {a_half[LANE_W-1], a_half};
        b_x      = {b_pick[LANE_W-1], b_pick};
        lane_res = do_sub ? (a_x - b_x) : (a_x + b_x);
    end
endmodule

// File: rtl/phsimd_unit.sv
// Top: packed signed halfword add/subtract/crossed unit with a
// registered output stage. It assumes LANES is even, because the crossed
// mode pairs lane 2k with lane 2k+1. Result and flags are held registers
// that change only on a committed request.
module phsimd_unit
    import phs_pkg::*;
#(
    parameter int LANE_W        = 16,
    parameter int LANES         = 2,
    parameter int IDX_W         = 4,
    parameter int FORBIDDEN_IDX = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [3:0]               op_code,
    input  logic [IDX_W-1:0]         src_a_idx,
    input  logic [IDX_W-1:0]         src_b_idx,
    input  logic [IDX_W-1:0]         dst_idx,
    input  logic [LANE_W*LANES-1:0]  opnd_a,
    input  logic [LANE_W*LANES-1:0]  opnd_b,
    input  logic                     cond_en,
    output logic                     out_valid,
    output logic                     out_write,
    output logic [IDX_W-1:0]         out_dst,
    output logic [LANE_W*LANES-1:0]  result,
    output logic [2*LANES-1:0]       ge_flags,
    output logic                     illegal
);
    localparam int DATA_W = LANE_W * LANES;
    localparam int GE_W   = 2 * LANES;

    phs_mode_e         mode;
    logic              legal;
    logic [DATA_W-1:0] next_res;
    logic [GE_W-1:0]   next_ge;
    logic              commit;

    phs_decode #(
        .IDX_W         (IDX_W),
        .FORBIDDEN_IDX (FORBIDDEN_IDX)
    ) u_decode (
        .op_code   (op_code),
        .src_a_idx (src_a_idx),
        .src_b_idx (src_b_idx),
        .dst_idx   (dst_idx),
        .mode      (mode),
        .legal     (legal)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int PART = l ^ 1;
        logic [LANE_W:0] lane_res;

        phs_lane #(
            .LANE_W    (LANE_W),
            .EVEN_LANE ((l % 2) == 0)
        ) u_lane (
            .mode     (mode),
            .a_half   (opnd_a[l*LANE_W +: LANE_W]),
            .b_same   (opnd_b[l*LANE_W +: LANE_W]),
            .b_cross  (opnd_b[PART*LANE_W +: LANE_W]),
            .lane_res (lane_res)
        );

        // Pack the truncated lane value and its duplicated sign flag pair.
        always_comb begin
            next_res[l*LANE_W +: LANE_W] = lane_res[LANE_W-1:0];
            next_ge[2*l +: 2]            = {2{~lane_res[LANE_W]}};
        end
    end

    // A request commits only when it is valid, legal and enabled.
    always_comb commit = in_valid && legal && cond_en;

    // Response strobe, status and destination index, one cycle late.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_write <= 1'b0;
            illegal   <= 1'b0;
            out_dst   <= '0;
        end else begin
            out_valid <= in_valid;
            out_write <= commit;
            illegal   <= in_valid && !legal;
            if (in_valid) out_dst <= dst_idx;
        end
    end

    // Held result and flags, updated only on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            ge_flags <= '0;
        end else if (commit) begin
            result   <= next_res;
            ge_flags <= next_ge;
        end
    end
endmodule

// File: rtl/phsimd_unit_checker.sv
// Checker: temporal properties of the packed unit, attached by bind.
// It sees only the top-level ports and assumes the default index width.
module phsimd_unit_checker #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32,
    parameter int GE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op_code,
    input logic [IDX_W-1:0]  src_a_idx,
    input logic [IDX_W-1:0]  src_b_idx,
    input logic [IDX_W-1:0]  dst_idx,
    input logic              cond_en,
    input logic              out_valid,
    input logic              out_write,
    input logic [DATA_W-1:0] result,
    input logic [GE_W-1:0]   ge_flags,
    input logic              illegal
);
    localparam logic [IDX_W-1:0] BAD = '1;

    p_valid_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_ge_pairs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ge_flags[0] == ge_flags[1]) && (ge_flags[2] == ge_flags[3]));
    p_bad_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ((src_a_idx == BAD) || (src_b_idx == BAD) || (dst_idx == BAD))
        |=> illegal && !out_write);
    p_bad_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op_code != 4'b0001) && (op_code != 4'b0111) && (op_code != 4'b0011)
        |=> illegal && !out_write);
    p_cond_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !cond_en |=> !out_write);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_write |-> $stable(result) && $stable(ge_flags));
endmodule

bind phsimd_unit phsimd_unit_checker #(
    .IDX_W  (IDX_W),
    .DATA_W (LANE_W*LANES),
    .GE_W   (2*LANES)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .src_a_idx (src_a_idx),
    .src_b_idx (src_b_idx),
    .dst_idx   (dst_idx),
    .cond_en   (cond_en),
    .out_valid (out_valid),
    .out_write (out_write),
    .result    (result),
    .ge_flags  (ge_flags),
    .illegal   (illegal)
);

// File: tb/phsimd_unit_bench.sv
`timescale 1ns/1ps
module phsimd_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [3:0]  src_a_idx = '0, src_b_idx = '0, dst_idx = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        cond_en = 1'b0;
    logic        out_valid, out_write, illegal;
    logic [3:0]  out_dst;
    logic [31:0] result;
    logic [3:0]  ge_flags;

    int checks = 0;
    int failures = 0;
    logic [31:0] held_res = '0;
    logic [3:0]  held_ge = '0;

    always #2.5 clk = ~clk;

    phsimd_unit u_phsimd_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .dst_idx(dst_idx),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .cond_en(cond_en),
        .out_valid(out_valid), .out_write(out_write), .out_dst(out_dst),
        .result(result), .ge_flags(ge_flags), .illegal(illegal)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: full-precision lanes from the requirement text.
    task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic [3:0] g);
        int al, ah, bl, bh, l0, l1;
        al = {{16{a[15]}}, a[15:0]};
        ah = {{16{a[31]}}, a[31:16]};
        bl = {{16{b[15]}}, b[15:0]};
        bh = {{16{b[31]}}, b[31:16]};
        if (op == 4'b0001) begin l0 = al + bl; l1 = ah + bh; end
        else if (op == 4'b0111) begin l0 = al - bl; l1 = ah - bh; end
        else begin l0 = al - bh; l1 = ah + bl; end
        r = {l1[15:0], l0[15:0]};
        g = {{2{l1 >= 0}}, {2{l0 >= 0}}};
    endtask

    // Issue one request, then sample at the negedge after the capturing edge.
    task automatic issue(input logic [3:0] op, input logic [3:0] ia, input logic [3:0] ib,
                         input logic [3:0] id, input logic [31:0] a, input logic [31:0] b,
                         input logic ce);
        @(negedge clk);
        in_valid = 1'b1; op_code = op; src_a_idx = ia; src_b_idx = ib;
        dst_idx = id; opnd_a = a; opnd_b = b; cond_en = ce;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_legal(input logic [3:0] op, input logic [31:0] a,
                             input logic [31:0] b, input string req);
        logic [31:0] er;
        logic [3:0]  eg;
        model(op, a, b, er, eg);
        issue(op, 4'd1, 4'd2, 4'd3, a, b, 1'b1);
        check(result == er, req, result, er);
        check(ge_flags == eg, {req, " R5 flags"}, 32'(ge_flags), 32'(eg));
        check(out_write && !illegal && out_dst == 4'd3, {req, " R6 write"},
              {out_write, illegal, out_dst}, {1'b1, 1'b0, 4'd3});
        held_res = er;
        held_ge  = eg;
    endtask

    task automatic t_reset();
        check(result == 0 && ge_flags == 0, "R10 data", {ge_flags, result[27:0]}, 0);
        check(!out_valid && !out_write && !illegal && out_dst == 0, "R10 status",
              {out_valid, out_write, illegal, out_dst}, 0);
    endtask

    task automatic t_add();   // R1, R4
        run_legal(4'b0001, 32'h0003_FFFE, 32'hFFFB_0005, "R1 mixed");
        run_legal(4'b0001, 32'h8000_7FFF, 32'h8000_7FFF, "R1 R4 extremes");
    endtask

    task automatic t_sub();   // R2, R4
        run_legal(4'b0111, 32'h0010_0001, 32'h0020_0001, "R2 mixed");
        run_legal(4'b0111, 32'h7FFF_8000, 32'hFFFF_7FFF, "R2 R4 extremes");
    endtask

    task automatic t_exch();  // R3
        run_legal(4'b0011, 32'h0100_0010, 32'h0002_0030, "R3 cross");
        run_legal(4'b0011, 32'h7FFF_8000, 32'h0001_7FFF, "R3 R4 extremes");
    endtask

    task automatic t_bad_idx();  // R7
        issue(4'b0001, 4'd15, 4'd2, 4'd3, 32'h1111_1111, 32'h1111_1111, 1'b1);
        check(illegal && !out_write, "R7 src_a", {illegal, out_write}, 2'b10);
        check(result == held_res && ge_flags == held_ge, "R7 hold", result, held_res);
        issue(4'b0111, 4'd1, 4'd2, 4'd15, 32'h2222_2222, 32'h0001_0001, 1'b1);
        check(illegal && !out_write && result == held_res, "R7 dst", result, held_res);
    endtask

    task automatic t_bad_op();   // R8
        issue(4'b0101, 4'd1, 4'd2, 4'd3, 32'h0FFF_0FFF, 32'h0FFF_0FFF, 1'b1);
        check(illegal && !out_write, "R8 flag", {illegal, out_write}, 2'b10);
        check(result == held_res && ge_flags == held_ge, "R8 hold", result, held_res);
    endtask

    task automatic t_cond_off(); // R9
        issue(4'b0001, 4'd1, 4'd2, 4'd3, 32'h8000_8000, 32'h8000_8000, 1'b0);
        check(!out_write && !illegal, "R9 status", {out_write, illegal}, 0);
        check(result == held_res && ge_flags == held_ge, "R9 hold", result, held_res);
    endtask

    task automatic t_valid();    // R6
        issue(4'b0001, 4'd1, 4'd2, 4'd3, 32'h0, 32'h0, 1'b1);
        check(out_valid, "R6 strobe", 32'(out_valid), 1);
        @(negedge clk);
        check(!out_valid, "R6 single", 32'(out_valid), 0);
        held_res = 0; held_ge = 4'hF;
        check(ge_flags == 4'hF && result == 0, "R5 zero", {ge_flags, result[27:0]}, 32'hF000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_exch();
        t_bad_idx();
        t_bad_op();
        t_cond_off();
        t_valid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule